// File: doc/BRIEF.md
# Configurable Timer with Prescaler

This block is a timer/counter that counts either a one-cycle instruction-rate tick or edges seen on an external clock pin. The pin is asynchronous. A power-of-two prescaler can divide the selected source, or it can be bypassed. The counter runs as 8 or 16 bits. When it wraps from all ones to zero it raises a sticky overflow flag, and software clears that flag. A host reaches the block through a small synchronous register port.

The host sets all modes with one control byte. Each step of the host is a single register read or write. The counter is split into a low byte and a high byte. The high byte is buffered on both the read path and the write path, so a 16-bit value is always read and written as one consistent pair.

Register addresses on `addr_i`:

| Address | Register |
|---|---|
| 0 | Control byte |
| 1 | Count low byte |
| 2 | Count high byte, through its buffers |
| 3 | Status: bit 0 is the overflow flag |

Top module: `cfg_timer`

## Requirements
- R1: After reset the control byte reads 0xFF, both count bytes read 0x00 and the overflow flag reads 0.
- R2: Control bit 7 (run) at 0 freezes the count and the prescaler. Register writes still load the count.
- R3: Control bit 6 at 1 selects 8-bit counting. In this mode the low byte wraps from 0xFF to 0x00 and the high byte never changes. At 0, the full 16-bit count wraps from 0xFFFF to 0x0000, and 0x00FF steps to 0x0100.
- R4: Control bit 5 at 0 counts cycles in which `tick_i` is high, and the pin is ignored. At 1, the block counts edges on `ext_pin_i` and ignores `tick_i`.
- R5: Control bit 4 selects the pin edge: 1 counts high-to-low edges and 0 counts low-to-high edges. Each qualifying edge gives exactly one count. If the pin changes between clock edges, the count is first visible after the third clock edge that follows.
- R6: Control bit 3 at 1 bypasses the prescaler, so every source event advances the count.
- R7: With the prescaler in use, control bits 2:0 = k make 2^(k+1) source events produce one count step. So 000 gives 1:2 and 111 gives 1:256.
- R8: A wrap sets the overflow flag. The flag stays set until a write to address 3 with data bit 0 = 1. If a wrap and a clear happen in the same cycle, the flag stays set.
- R9: A read of address 1 copies the high count byte into a read buffer. Reads of address 2 return that buffer.
- R10: A write to address 2 only fills a write buffer. A write to address 1 loads the count from {write buffer, data} in 16-bit mode, and loads only the low byte in 8-bit mode.
- R11: Any write to address 0, 1 or 2 restarts the prescaler from zero.
- R12: A count load by a write takes precedence over an increment in the same cycle, and that cycle raises no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Instruction-rate tick, one count event per high cycle |
| ext_pin_i | input | 1 | Asynchronous external clock pin |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read side effects) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the address |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The hardest cases to reach from the ports are the ones where two events land on the same clock edge: a wrap together with a flag clear, and a counter load together with a tick. The bench reaches them by preloading the counter through the buffered write path to one step below the wrap. It then drives the write strobe and `tick_i` on the same negative clock edge. A second hard case is prescaler restart, because the prescaler state is not visible at the ports. The bench leaves a partial prescale count pending, rewrites a register, and counts how many more ticks it takes before the counter moves.

// File: rtl/cfg_timer_pkg.sv
package cfg_timer_pkg;

    localparam int DATA_W   = 8;
    localparam int CNT_W    = 2 * DATA_W;
    localparam int PS_SEL_W = 3;
    localparam int PS_W     = 1 << PS_SEL_W;

    // Field order follows the control byte bit positions (bit 7 first).
    typedef struct packed {
        logic                run;
        logic                narrow;
        logic                ext_src;
        logic                fall_edge;
        logic                ps_bypass;
        logic [PS_SEL_W-1:0] ps_sel;
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        A_CTRL   = 2'd0,
        A_CNT_LO = 2'd1,
        A_CNT_HI = 2'd2,
        A_STATUS = 2'd3
    } tmr_addr_e;

    // Terminal prescaler count for a ratio of 2^(sel+1).
    function automatic logic [PS_W-1:0] ps_last(input logic [PS_SEL_W-1:0] sel);
        logic [PS_W:0] full;
        full = (PS_W+1)'(1) << (sel + 1);
        return PS_W'(full - 1'b1);
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[SYNC_STAGES-1];
    end

    always_comb begin
        if (fall_sel_i) edge_o = last_q & ~chain_q[SYNC_STAGES-1];
        else            edge_o = ~last_q & chain_q[SYNC_STAGES-1];
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import cfg_timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                hold_i,
    input  logic                bypass_i,
    input  logic [PS_SEL_W-1:0] sel_i,
    input  logic                pulse_i,
    output logic                inc_o,
    output logic [PS_W-1:0]     pre_o
);
    logic [PS_W-1:0] pre_q;
    logic            at_last;
    logic            step;

    always_comb begin
        at_last = (pre_q == ps_last(sel_i));
        step    = pulse_i & ~hold_i;
        inc_o   = step & (bypass_i | at_last);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pre_q <= '0;
        end else if (step && !bypass_i) begin
            pre_q <= at_last ? '0 : pre_q + 1'b1;
        end
    end

    assign pre_o = pre_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             narrow_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] cnt_q;
    logic             low_ones;
    logic             all_ones;

    always_comb begin
        low_ones = &cnt_q[HALF-1:0];
        all_ones = &cnt_q;
        wrap_o   = inc_i & ~load_i & (narrow_i ? low_ones : all_ones);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            if (narrow_i) cnt_q[HALF-1:0] <= load_val_i[HALF-1:0];
            else          cnt_q           <= load_val_i;
        end else if (inc_i) begin
            if (narrow_i) cnt_q[HALF-1:0] <= cnt_q[HALF-1:0] + 1'b1;
            else          cnt_q           <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer
    import cfg_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              ext_pin_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ovf_flag_o
);
    tmr_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] hi_wbuf_q;
    logic [DATA_W-1:0] hi_rbuf_q;
    logic              ovf_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PS_W-1:0]   pre_q;

    logic wr_ctrl, wr_lo, wr_hi, wr_stat, rd_lo;
    logic ext_edge, src_pulse, inc, wrap;

    always_comb begin
        wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
        wr_lo     = wr_en_i && (addr_i == A_CNT_LO);
        wr_hi     = wr_en_i && (addr_i == A_CNT_HI);
        wr_stat   = wr_en_i && (addr_i == A_STATUS);
        rd_lo     = rd_en_i && (addr_i == A_CNT_LO);
        src_pulse = ctrl_q.ext_src ? ext_edge : tick_i;
    end

    tmr_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (ext_pin_i),
        .fall_sel_i (ctrl_q.fall_edge),
        .edge_o     (ext_edge)
    );

    tmr_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (wr_ctrl | wr_lo | wr_hi),
        .hold_i   (~ctrl_q.run),
        .bypass_i (ctrl_q.ps_bypass),
        .sel_i    (ctrl_q.ps_sel),
        .pulse_i  (src_pulse),
        .inc_o    (inc),
        .pre_o    (pre_q)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .inc_i      (inc),
        .narrow_i   (ctrl_q.narrow),
        .load_i     (wr_lo),
        .load_val_i ({hi_wbuf_q, wdata_i}),
        .cnt_o      (cnt_q),
        .wrap_o     (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= tmr_ctrl_t'('1);
            hi_wbuf_q <= '0;
            hi_rbuf_q <= '0;
            ovf_q     <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q    <= tmr_ctrl_t'(wdata_i);
            if (wr_hi)   hi_wbuf_q <= wdata_i;
            if (rd_lo)   hi_rbuf_q <= cnt_q[CNT_W-1:DATA_W];
            if (wrap)                       ovf_q <= 1'b1;
            else if (wr_stat && wdata_i[0]) ovf_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr_i)
            A_CTRL:   rdata_o = ctrl_q;
            A_CNT_LO: rdata_o = cnt_q[DATA_W-1:0];
            A_CNT_HI: rdata_o = hi_rbuf_q;
            default:  rdata_o = {{(DATA_W-1){1'b0}}, ovf_q};
        endcase
    end

    assign ovf_flag_o = ovf_q;
endmodule

// File: rtl/cfg_timer_chk.sv
module cfg_timer_chk
    import cfg_timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              flag_q,
    input logic [PS_W-1:0]   pre_q,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata
);
    logic clr_req, lo_wr, any_cfg_wr;
    assign clr_req    = wr_en && (addr == 2'd3) && wdata[0];
    assign lo_wr      = wr_en && (addr == 2'd1);
    assign any_cfg_wr = wr_en && (addr != 2'd3);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        flag_q && !clr_req |=> flag_q);

    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[7] && !lo_wr |=> $stable(cnt_q));

    assert_narrow_high_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[6] |=> $stable(cnt_q[CNT_W-1:DATA_W]));

    assert_wrap_point_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> ($past(ctrl_q[6])
            ? ($past(cnt_q[DATA_W-1:0]) == '1 && cnt_q[DATA_W-1:0] == '0)
            : ($past(cnt_q) == '1 && cnt_q == '0)));

    assert_pre_range_R7: assert property (@(posedge clk) disable iff (rst)
        pre_q <= ps_last(ctrl_q[PS_SEL_W-1:0]));

    assert_pre_restart_R11: assert property (@(posedge clk) disable iff (rst)
        any_cfg_wr |=> pre_q == '0);
endmodule

bind cfg_timer cfg_timer_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .ctrl_q (ctrl_q),
    .cnt_q  (cnt_q),
    .flag_q (ovf_q),
    .pre_q  (pre_q),
    .wr_en  (wr_en_i),
    .addr   (addr_i),
    .wdata  (wdata_i)
);

// File: tb/cfg_timer_test.sv
module cfg_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       ext_pin_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [1:0] addr_i = 2'd0;
    logic [7:0] wdata_i = 8'd0;
    logic [7:0] rdata_o;
    logic       ovf_flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cfg_timer uut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .ext_pin_i(ext_pin_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .ovf_flag_o(ovf_flag_o)
    );

    // {ctrl, ticks, preload, expected count, expected flag}
    localparam int NV = 10;
    localparam logic [56:0] VEC [NV] = '{
        {8'h88, 16'd3,   16'h00FE, 16'h0101, 1'b0},  // R3 R6 carry
        {8'h88, 16'd3,   16'hFFFE, 16'h0001, 1'b1},  // R3 R8 16-bit wrap
        {8'hC8, 16'd3,   16'h12FE, 16'h1201, 1'b1},  // R3 8-bit wrap
        {8'h80, 16'd5,   16'h0000, 16'h0002, 1'b0},  // R7 1:2
        {8'h82, 16'd20,  16'h0000, 16'h0002, 1'b0},  // R7 1:8
        {8'h87, 16'd600, 16'h0000, 16'h0002, 1'b0},  // R7 1:256
        {8'h81, 16'd4,   16'hFFFF, 16'h0000, 1'b1},  // R7 R8 1:4 wrap
        {8'h08, 16'd5,   16'h0034, 16'h0034, 1'b0},  // R2 stopped
        {8'hA8, 16'd5,   16'h0050, 16'h0050, 1'b0},  // R4 ticks ignored
        {8'hC3, 16'd320, 16'h34F0, 16'h3404, 1'b1}   // R3 R7 8-bit 1:16
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        #1 d = rdata_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic preload(input logic [15:0] v);
        wr(2'd0, 8'h08);
        wr(2'd2, v[15:8]);
        wr(2'd1, v[7:0]);
        wr(2'd3, 8'h01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, b);  check("R1 ctrl", b, 8'hFF);
        rd16(v);      check("R1 count", v, 16'h0000);
        rd(2'd3, b);  check("R1 flag", b, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  vc;
            logic [15:0] vt, vp, ve;
            logic        vf;
            {vc, vt, vp, ve, vf} = VEC[i];
            preload(vp);
            wr(2'd0, vc);
            ticks(int'(vt));
            rd16(v);
            check($sformatf("R3/R4/R6/R7 vector %0d count", i), v, ve);
            rd(2'd3, b);
            check($sformatf("R8 vector %0d flag", i), b, {7'd0, vf});
        end

        // R8 clear, write of 0 has no effect
        preload(16'hFFFF);
        wr(2'd0, 8'h88);
        ticks(1);
        wr(2'd3, 8'h00);
        rd(2'd3, b);  check("R8 flag kept by zero write", b, 8'h01);
        wr(2'd3, 8'h01);
        rd(2'd3, b);  check("R8 flag cleared", b, 8'h00);

        // R8 wrap and clear in same cycle: set wins
        preload(16'hFFFF);
        wr(2'd0, 8'h88);
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 2'd3; wdata_i = 8'h01;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        rd(2'd3, b);  check("R8 set beats clear", b, 8'h01);

        // R12 load beats increment, no overflow
        preload(16'h00FF);
        wr(2'd0, 8'h88);
        wr(2'd2, 8'h00);
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 2'd1; wdata_i = 8'h40;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        rd16(v);      check("R12 load wins", v, 16'h0040);
        rd(2'd3, b);  check("R12 no flag", b, 8'h00);

        // R9 read buffer latched by low-byte read
        preload(16'h1234);
        rd(2'd1, b);  check("R9 low", b, 8'h34);
        wr(2'd2, 8'h56);
        wr(2'd1, 8'h78);
        rd(2'd2, b);  check("R9 buffered high", b, 8'h12);
        rd16(v);      check("R9 new value", v, 16'h5678);

        // R10 high write deferred; narrow mode loads low only
        wr(2'd2, 8'hAB);
        rd16(v);      check("R10 high deferred", v, 16'h5678);
        wr(2'd1, 8'h01);
        rd16(v);      check("R10 pair load", v, 16'hAB01);
        wr(2'd0, 8'h48);
        wr(2'd2, 8'hCD);
        wr(2'd1, 8'h11);
        rd16(v);      check("R10 narrow load", v, 16'hAB11);

        // R11 prescaler restart on ctrl write and count write
        preload(16'h0000);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h81);
        ticks(3);
        wr(2'd0, 8'h81);
        ticks(3);
        rd16(v);      check("R11 ctrl write restart", v, 16'h0000);
        ticks(1);
        rd16(v);      check("R11 after four", v, 16'h0001);
        ticks(3);
        wr(2'd1, 8'h00);
        ticks(3);
        rd16(v);      check("R11 count write restart", v, 16'h0000);

        // R5 R4 external edges and latency
        preload(16'h0000);
        wr(2'd0, 8'hA8);
        @(negedge clk);
        addr_i = 2'd1;
        ext_pin_i = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); #1 check("R5 not yet after two edges", rdata_o, 8'h00);
        @(posedge clk);
        @(negedge clk); #1 check("R5 visible after third edge", rdata_o, 8'h01);
        ext_pin_i = 1'b0;
        repeat (5) @(negedge clk);
        #1 check("R5 falling ignored in rising mode", rdata_o, 8'h01);
        wr(2'd0, 8'hB8);
        ext_pin_i = 1'b1;
        repeat (5) @(negedge clk);
        addr_i = 2'd1;
        #1 check("R5 rising ignored in falling mode", rdata_o, 8'h01);
        ext_pin_i = 1'b0;
        repeat (5) @(negedge clk);
        #1 check("R4 R5 one falling edge one count", rdata_o, 8'h02);

        // R4 pin ignored with internal source
        wr(2'd0, 8'h88);
        ext_pin_i = 1'b1;
        repeat (5) @(negedge clk);
        ext_pin_i = 1'b0;
        repeat (5) @(negedge clk);
        addr_i = 2'd1;
        #1 check("R4 pin ignored", rdata_o, 8'h02);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule